// File: doc/BRIEF.md
# Iterative Bit Deposit Unit

The block scatters the low-order bits of a 32-bit source word into the bit positions selected by a mask. The lowest set bit of the mask receives source bit 0, the next set bit receives source bit 1, and so on. Every result position where the mask is clear reads 0.

The unit is sequential and handles one set mask bit per clock. On each step it isolates the lowest remaining mask bit by ANDing the mask with its two's-complement negation, then removes that bit with an XOR. A one-hot source selector starts at bit 0 and doubles after every step, so the datapath needs no variable shifter. The selected source bit is widened to a full-width word by negation and ANDed with the isolated bit, and the product is ORed into an accumulator. The walk stops when no mask bits remain. Latency therefore tracks the population count of the mask, and an all-zero mask completes immediately.

A caller pulses `start` with `source` and `mask` valid while the unit is idle. It then waits for the one-cycle `done` pulse and reads `result`, which stays stable until the next completion.

Top module: `bdep_unit`

## Requirements
- R1: For every mask and source, result bit p equals source bit j when p is the position of the (j+1)-th set mask bit counted upward from bit 0, and result bit p is 0 wherever mask bit p is 0.
- R2: Mask 0x0000002E with source 0x00000006 yields result 0x0000000C.
- R3: Mask 0x00000099 with source 0x0000000D yields result 0x00000091.
- R4: Source bits at index k and above, where k is the mask's population count, have no effect on the result.
- R5: For a mask with k set bits (k ≥ 1), busy is high for exactly k consecutive cycles starting in the cycle after start is sampled, and done is high in the cycle after busy drops. For a zero mask, busy stays low, done is high in the cycle after start, and result is 0.
- R6: done is high for exactly one cycle per operation and is never high while busy is high.
- R7: result changes only in the cycle in which done is high. Otherwise it keeps its value, including while a later operation is in progress.
- R8: A start pulse that arrives while busy is high is ignored. The running operation completes with its original operands and its original latency.
- R9: While reset is high and after it is released, busy and done are low and result is 0.
- R10: Mask 0xFFFFFFFF returns the source unchanged after 32 busy cycles, the longest walk at the default width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when the unit is idle |
| source | input | 32 | Bits to be deposited, consumed from bit 0 upward |
| mask | input | 32 | Selects the result positions that receive source bits |
| busy | output | 1 | High while mask bits remain to be processed |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Deposited word, held between completions |

## Verification
The bench builds the unit with its default width of 32 bits. This default brings the two extremes of the walk within reach: a full mask that takes 32 steps and drives the selector up to the top source bit, and a mask whose only set bit is the most significant one, which tests isolation at the sign position of the two's-complement negation. Sparse, dense, alternating and nibble-patterned masks are paired with sources whose upper bits are set, so that the bench can show those bits are ignored. Busy cycles are counted against the bench's own population count of each mask.

// File: rtl/bdep_pkg.sv
package bdep_pkg;

    // Default operand width of the deposit unit.
    localparam int unsigned BDEP_W_DEF = 32;

    // Controller states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } bdep_state_e;

    // Working registers of one deposit operation.
    typedef struct packed {
        logic [BDEP_W_DEF-1:0] rem_mask;  // mask bits still to be consumed
        logic [BDEP_W_DEF-1:0] src;       // latched source word
        logic [BDEP_W_DEF-1:0] sel;       // one-hot source selector
        logic [BDEP_W_DEF-1:0] acc;       // partial result
    } bdep_work_t;

endpackage

// File: rtl/bdep_lowbit.sv
module bdep_lowbit #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] low_o,   // lowest set bit of vec_i, one-hot or zero
    output logic [W-1:0] rest_o   // vec_i with that bit removed
);
    logic [W-1:0] neg_vec;

    always_comb begin
        neg_vec = '0 - vec_i;
        low_o   = vec_i & neg_vec;
        rest_o  = vec_i ^ low_o;
    end
endmodule

// File: rtl/bdep_step.sv
module bdep_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem_mask_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] sel_i,
    input  logic [W-1:0] acc_i,
    output logic [W-1:0] rem_mask_o,
    output logic [W-1:0] sel_o,
    output logic [W-1:0] acc_o,
    output logic         last_o      // this step consumes the final mask bit
);
    logic [W-1:0] low_bit;
    logic [W-1:0] spread;

    bdep_lowbit #(.W(W)) u_low (
        .vec_i  (rem_mask_i),
        .low_o  (low_bit),
        .rest_o (rem_mask_o)
    );

    always_comb begin
        // Negating the isolated source bit sets it and every bit above it.
        spread = '0 - (src_i & sel_i);
        acc_o  = acc_i | (low_bit & spread);
        sel_o  = sel_i + sel_i;
        last_o = (rem_mask_o == '0);
    end
endmodule

// File: rtl/bdep_ctrl.sv
module bdep_ctrl
    import bdep_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic mask_zero_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o,
    output logic done_o
);
    bdep_state_e state_q, state_d;
    logic        done_q;

    always_comb begin
        load_o   = (state_q == ST_IDLE) && start_i;
        step_o   = (state_q == ST_WALK);
        finish_o = (load_o && mask_zero_i) || (step_o && last_i);
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: if (load_o && !mask_zero_i) state_d = ST_WALK;
            ST_WALK: if (last_i)                 state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish_o;
        end
    end

    assign busy_o = (state_q == ST_WALK);
    assign done_o = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                       // R6
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));                                      // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !last_i) |=> (busy_o && !done_o));   // R8
endmodule

// File: rtl/bdep_unit.sv
module bdep_unit
    import bdep_pkg::*;
#(
    parameter int unsigned W = BDEP_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] source,
    input  logic [W-1:0] mask,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [W-1:0] SEL_INIT = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] rem_q, src_q, sel_q, acc_q, res_q;
    logic [W-1:0] rem_n, sel_n, acc_n;
    logic         last, load, step, finish;

    bdep_step #(.W(W)) u_step (
        .rem_mask_i (rem_q),
        .src_i      (src_q),
        .sel_i      (sel_q),
        .acc_i      (acc_q),
        .rem_mask_o (rem_n),
        .sel_o      (sel_n),
        .acc_o      (acc_n),
        .last_o     (last)
    );

    bdep_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .mask_zero_i (mask == '0),
        .last_i      (last),
        .load_o      (load),
        .step_o      (step),
        .finish_o    (finish),
        .busy_o      (busy),
        .done_o      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            src_q <= '0;
            sel_q <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (load) begin
                rem_q <= mask;
                src_q <= source;
                sel_q <= SEL_INIT;
                acc_q <= '0;
            end else if (step) begin
                rem_q <= rem_n;
                sel_q <= sel_n;
                acc_q <= acc_n;
            end
            if (finish) res_q <= step ? acc_n : '0;
        end
    end

    assign result = res_q;

    // Length of the current busy run, used to bound the walk.
    logic [CW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < CW'(W)));                                // R5
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mask == '0) |=> (done && result == '0)); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));                                // R7
endmodule

// File: tb/sim_bdep_unit.sv
module sim_bdep_unit;
    localparam int W = 32;
    localparam int NV = 10;
    // {mask, source, expected}
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000002E, 32'h00000006, 32'h0000000C},  // R2
        {32'h00000099, 32'h0000000D, 32'h00000091},  // R3
        {32'h80000000, 32'hFFFFFFFF, 32'h80000000},
        {32'hFFFFFFFF, 32'hDEADBEEF, 32'hDEADBEEF},  // R10
        {32'hAAAAAAAA, 32'h0000FFFF, 32'hAAAAAAAA},
        {32'h0000FFFF, 32'h12345678, 32'h00005678},  // R4
        {32'hF0F0F0F0, 32'hFFFFA5C3, 32'hA050C030},  // R4
        {32'h00000001, 32'hFFFFFFFE, 32'h00000000},  // R4
        {32'h00000000, 32'hFFFFFFFF, 32'h00000000},  // R5 zero mask
        {32'h00010001, 32'h00000002, 32'h00010000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] source = '0;
    logic [W-1:0] mask = '0;
    logic         busy, done;
    logic [W-1:0] result;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bdep_unit #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .source(source),
        .mask(mask), .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_dep(input logic [31:0] m, input logic [31:0] s);
        logic [31:0] r = '0;
        int j = 0;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
                r[i] = s[j];
                j++;
            end
        end
        return r;
    endfunction

    function automatic int pop(input logic [31:0] m);
        int c = 0;
        for (int i = 0; i < 32; i++) c += int'(m[i]);
        return c;
    endfunction

    task automatic run_op(input logic [31:0] m, input logic [31:0] s,
                          output logic [31:0] res, output int bcnt, output bit ok);
        @(negedge clk);
        start = 1'b1; mask = m; source = s;
        @(negedge clk);
        start = 1'b0;
        bcnt = 0; ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin ok = 1'b1; break; end
            if (busy) bcnt++;
            @(negedge clk);
        end
        res = result;
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] res, held;
        int bc;
        bit ok;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && result == '0, "R9 during reset", {30'd0, busy, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && result == '0, "R9 after reset", result, 32'd0);

        // Table walk: R1..R5, R10
        for (int v = 0; v < NV; v++) begin
            logic [31:0] m, s, e;
            {m, s, e} = VEC[v];
            run_op(m, s, res, bc, ok);
            chk(ok, "R5 done seen", {31'd0, ok}, 32'd1);
            chk(res == e, $sformatf("R1/R2/R3/R4/R10 vec %0d", v), res, e);
            chk(res == ref_dep(m, s), $sformatf("R1 model vec %0d", v), res, ref_dep(m, s));
            chk(bc == pop(m), $sformatf("R5 busy cycles vec %0d", v), bc, pop(m));
            @(negedge clk);
            chk(!done, "R6 done one cycle", {31'd0, done}, 32'd0);
            chk(result == res, "R7 result held after done", result, res);
        end

        // R4: same mask, different upper source bits
        run_op(32'h00F0000F, 32'h000000A5, res, bc, ok);
        held = res;
        run_op(32'h00F0000F, 32'hFFFFFFA5, res, bc, ok);
        chk(res == held && res == 32'h00A00005, "R4 upper source ignored", res, 32'h00A00005);

        // R7: result unchanged while the next operation runs
        @(negedge clk);
        start = 1'b1; mask = 32'h000000FF; source = 32'h0;
        @(negedge clk);
        start = 1'b0;
        chk(busy && result == 32'h00A00005, "R7 held while busy", result, 32'h00A00005);
        for (int i = 0; i < 50 && !done; i++) @(negedge clk);
        chk(done && result == 32'h0, "R7 updated at done", result, 32'h0);

        // R8: start during busy is ignored
        @(negedge clk);
        start = 1'b1; mask = 32'hFFFFFFFF; source = 32'h0F0F0F0F;
        @(negedge clk);
        start = 1'b0;
        bc = 1;
        @(negedge clk);
        start = 1'b1; mask = 32'h00000001; source = 32'h0;
        bc++;
        @(negedge clk);
        start = 1'b0; mask = '0; source = '0;
        for (int i = 0; i < 100; i++) begin
            if (done) break;
            if (busy) bc++;
            @(negedge clk);
        end
        chk(done && result == 32'h0F0F0F0F, "R8 operands kept", result, 32'h0F0F0F0F);
        chk(bc == 32, "R8 latency kept", bc, 32);
        @(negedge clk);
        chk(!busy && !done, "R8 no restart", {30'd0, busy, done}, 32'd0);

        // R5: zero mask completes in the cycle after start with busy low
        @(negedge clk);
        start = 1'b1; mask = 32'h0; source = 32'hFFFFFFFF;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy && result == 32'h0, "R5 zero mask immediate", {30'd0, busy, done}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule